// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital controller for a dual sample-and-hold converter that runs in simultaneous mode. One of three start sources is selected: a PWM event pulse, a software start pulse, or the rising edge of an external start pin. When a start is accepted, the block locks a single 3-bit pair index. That index steers both the A and B channel multiplexers, so only matched pairs (A0/B0 up to A7/B7) can ever be converted. After a fixed delay the block raises a sample/hold pulse, and both channels are captured together on that pulse's falling edge.

The ADC clock is derived from the system clock. A half-period tick fires every `half_div + 1` system clocks, so one ADC clock period is `2 * (half_div + 1)` system clocks. This half-period resolution is what allows the 2.5-clock start delay. The two captured values travel down a short delay line. The A result register is written first and the B result register one ADC clock later. Two system clocks after the B write, a sticky interrupt flag is raised.

With `cont_en` held high the block keeps pulsing at a steady rate until `cont_en` is low at a falling edge. A start that arrives while a conversion is in flight is dropped and recorded in a sticky overrun bit. The converter itself is modelled outside the block: the block presents the locked pair index on `ana_pair`, and the values on `ana_a` / `ana_b` are taken at the hold edge.

Top module: `simsamp_adc_seq`

## Requirements
- R1: `trig_sel` picks the start source: 0 = `pwm_evt` high, 1 = `sw_start` high, 2 = rising edge of `ext_soc`, 3 = no source. Activity on any source that is not selected starts nothing.
- R2: `sh_pulse` rises 5 half-periods (2.5 ADC clocks) after the clock edge that accepts a start. One half-period is `half_div + 1` system clocks.
- R3: `sh_pulse` stays high for exactly `(1 + acqps)` ADC clocks. `acqps` is 0 to 15 and is taken when the start is accepted.
- R4: `pair_sel` is locked at acceptance and shown on `ana_pair` until the conversion ends. Later changes to `pair_sel` have no effect. `ana_a` and `ana_b` are both captured on the clock edge where `sh_pulse` falls.
- R5: `res_a` is written, with a one-cycle `res_a_stb`, 4 ADC clocks after the `sh_pulse` fall. `res_b` is written, with `res_b_stb`, 5 ADC clocks after that fall.
- R6: If `cont_en` is high when `sh_pulse` falls, another pulse follows. Successive A writes, and successive B writes, are `(3 + acqps)` ADC clocks apart. Every falling edge yields exactly one A write and one B write.
- R7: `int_flag` rises exactly 2 system clocks after a `res_b_stb` and stays set until `int_clr` is pulsed.
- R8: A start on the selected source while `busy` is high is ignored. It sets `overrun`, which stays set until `ovr_clr` is pulsed.
- R9: After reset, `busy`, `sh_pulse`, `res_a`, `res_b`, both strobes, `int_flag` and `overrun` are all 0.
- R10: `busy` is high from the edge that accepts a start until one system clock after the final B write. `sh_pulse` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_div | input | 4 | Half ADC period minus one, in system clocks |
| trig_sel | input | 2 | Start source select |
| pwm_evt | input | 1 | PWM event start pulse |
| sw_start | input | 1 | Software start pulse |
| ext_soc | input | 1 | External start pin (rising edge) |
| pair_sel | input | 3 | Channel pair index to convert |
| acqps | input | 4 | Acquisition width setting |
| cont_en | input | 1 | Continuous conversion enable |
| int_clr | input | 1 | Clears the interrupt flag |
| ovr_clr | input | 1 | Clears the overrun bit |
| ana_a | input | 12 | Converter value for channel A of the locked pair |
| ana_b | input | 12 | Converter value for channel B of the locked pair |
| ana_pair | output | 3 | Locked pair index driving both channel muxes |
| sh_pulse | output | 1 | Sample/hold pulse |
| busy | output | 1 | Conversion in progress |
| res_a | output | 12 | A-channel result register |
| res_b | output | 12 | B-channel result register |
| res_a_stb | output | 1 | One-cycle pulse when res_a is written |
| res_b_stb | output | 1 | One-cycle pulse when res_b is written |
| int_flag | output | 1 | Sticky conversion-done flag |
| overrun | output | 1 | Sticky ignored-start flag |

## Verification
Some properties are checked on every cycle by assertions:
- The hold pulse never exceeds its programmed tick count and always ends on exactly that count.
- The A and B writes never coincide.
- The interrupt flag only rises two cycles after a B write.
- The pair index stays frozen while busy.
- Overrun only rises during a busy period.
- The hold pulse is never seen while idle.

The absolute cycle placement of the pulse and of both writes, counted from the accepting edge, can only be shown by the bench's scenarios. The same holds for the captured data values, the spacing of results in continuous mode, and the rejection of unselected sources. The bench covers these across several divider and acquisition settings.

// File: rtl/simsamp_pkg.sv
// Shared types and timing constants for the simultaneous-sampling sequencer.
// All delays are counted in ADC half-periods (half-ticks).
package simsamp_pkg;

    typedef enum logic [1:0] {
        TRIG_PWM = 2'd0,
        TRIG_SW  = 2'd1,
        TRIG_EXT = 2'd2,
        TRIG_OFF = 2'd3
    } trig_src_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DELAY,
        SQ_HOLD,
        SQ_GAP,
        SQ_DRAIN
    } seq_state_e;

    // Start-to-pulse delay: 2.5 ADC clocks.
    localparam int DELAY_HT = 5;
    // Low gap between pulses in continuous mode: 2 ADC clocks.
    localparam int GAP_HT   = 4;
    // Hold-edge to A write: 4 ADC clocks.
    localparam int LAT_A_HT = 8;
    // Hold-edge to B write: 5 ADC clocks.
    localparam int LAT_B_HT = 10;

endpackage

// File: rtl/adc_timebase.sv
// Half-period tick generator for the ADC clock.
// A tick is asserted for one system clock every (half_div + 1) clocks.
// Assumes half_div is held static while a conversion runs.
// restart realigns the phase so that delays count from the accepting edge.
module adc_timebase #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             restart,
    output logic             half_tick
);

    logic [DIV_W-1:0] phase;

    // Phase counter: wraps at half_div and resets on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= '0;
        end else if (phase >= half_div) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign half_tick = (phase == half_div) && !restart;

endmodule

// File: rtl/adc_trig_select.sv
// Start-source multiplexer.
// The PWM and software sources are level pulses; the external pin is
// edge-detected so that a held-high pin gives a single start.
// Output trig is valid in the same cycle as the selected event.
module adc_trig_select
    import simsamp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trig_src_e sel,
    input  logic      pwm_evt,
    input  logic      sw_start,
    input  logic      ext_soc,
    output logic      trig
);

    logic ext_q;

    // Previous value of the external pin for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_soc;
        end
    end

    // Select the active start source.
    always_comb begin
        unique case (sel)
            TRIG_PWM: trig = pwm_evt;
            TRIG_SW:  trig = sw_start;
            TRIG_EXT: trig = ext_soc && !ext_q;
            default:  trig = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_sh_sequencer.sv
// Sample/hold sequencer.
// Accepts a start only when idle, locks the pair index and acquisition
// setting, waits DELAY_HT half-ticks, then drives the hold pulse for
// 2*(1+acq) half-ticks.
// capture marks the edge where the pulse falls.
// In continuous mode it re-pulses after GAP_HT half-ticks; otherwise it
// waits for the result pipe to empty.
// Assumes tick restarts on accept.
module adc_sh_sequencer
    import simsamp_pkg::*;
#(
    parameter  int PAIR_W = 3,
    parameter  int ACQ_W  = 4,
    localparam int CNT_W  = ACQ_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              tick,
    input  logic              pipe_busy,
    input  logic [PAIR_W-1:0] pair_sel,
    input  logic [ACQ_W-1:0]  acqps,
    input  logic              cont_en,
    input  logic              ovr_clr,
    output logic              accept,
    output logic              capture,
    output logic              sh,
    output logic              busy,
    output logic              overrun,
    output logic [PAIR_W-1:0] pair_q
);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [ACQ_W-1:0] acq_q;
    logic [CNT_W-1:0] hold_last;

    // Last count of the hold pulse: 2*(1+acq)-1 half-ticks.
    assign hold_last = {1'b0, acq_q, 1'b1};
    assign accept    = trig && (state == SQ_IDLE);
    assign capture   = (state == SQ_HOLD) && tick && (cnt == '0);
    assign busy      = (state != SQ_IDLE);

    // Main conversion state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            cnt    <= '0;
            sh     <= 1'b0;
            pair_q <= '0;
            acq_q  <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (trig) begin
                        state  <= SQ_DELAY;
                        cnt    <= CNT_W'(DELAY_HT - 1);
                        pair_q <= pair_sel;
                        acq_q  <= acqps;
                    end
                end
                SQ_DELAY, SQ_GAP: begin
                    if (tick) begin
                        if (cnt == '0) begin
                            state <= SQ_HOLD;
                            sh    <= 1'b1;
                            cnt   <= hold_last;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (tick) begin
                        if (cnt == '0) begin
                            sh <= 1'b0;
                            if (cont_en) begin
                                state <= SQ_GAP;
                                cnt   <= CNT_W'(GAP_HT - 1);
                            end else begin
                                state <= SQ_DRAIN;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                SQ_DRAIN: begin
                    if (!pipe_busy) begin
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Sticky overrun: a start seen while busy; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (trig && busy) begin
            overrun <= 1'b1;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end
    end

    // Checker state: half-ticks seen while the hold pulse is high.
    logic [CNT_W:0] ast_hold_ticks;
    always_ff @(posedge clk) begin
        if (!rst_n || !sh) begin
            ast_hold_ticks <= '0;
        end else if (tick) begin
            ast_hold_ticks <= ast_hold_ticks + 1'b1;
        end
    end

    AST_HOLD_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        sh |-> (ast_hold_ticks <= {1'b0, hold_last})) else $error("hold too long"); // R3
    AST_HOLD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh) |-> ($past(ast_hold_ticks) == {1'b0, $past(hold_last)})) else $error("hold width"); // R3

endmodule

// File: rtl/adc_result_pipe.sv
// Result delay line and interrupt flag.
// Captured A/B values enter a half-tick shift line at the hold edge.
// The A register is loaded at tap LAT_A_HT and the B register at tap
// LAT_B_HT.
// int_flag is set two system clocks after each B write.
// Assumes pulses are at least 6 half-ticks apart, so A and B writes never
// collide.
module adc_result_pipe
    import simsamp_pkg::*;
#(
    parameter  int DW    = 12,
    localparam int DEPTH = LAT_B_HT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          capture,
    input  logic [DW-1:0] samp_a,
    input  logic [DW-1:0] samp_b,
    input  logic          int_clr,
    output logic [DW-1:0] res_a,
    output logic [DW-1:0] res_b,
    output logic          a_stb,
    output logic          b_stb,
    output logic          int_flag,
    output logic          pipe_busy
);

    logic [DEPTH-1:0]         vld;
    logic [DEPTH-1:0][DW-1:0] da;
    logic [DEPTH-1:0][DW-1:0] db;
    logic                     b_stb_d1;

    assign pipe_busy = |vld;

    // Shift line advancing one stage per half-tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            da  <= '0;
            db  <= '0;
        end else if (tick) begin
            vld <= {vld[DEPTH-2:0], capture};
            da  <= {da[DEPTH-2:0], samp_a};
            db  <= {db[DEPTH-2:0], samp_b};
        end
    end

    // A result register write at its tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_a <= '0;
            a_stb <= 1'b0;
        end else begin
            a_stb <= tick && vld[LAT_A_HT-1];
            if (tick && vld[LAT_A_HT-1]) begin
                res_a <= da[LAT_A_HT-1];
            end
        end
    end

    // B result register write at the last tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_b <= '0;
            b_stb <= 1'b0;
        end else begin
            b_stb <= tick && vld[DEPTH-1];
            if (tick && vld[DEPTH-1]) begin
                res_b <= db[DEPTH-1];
            end
        end
    end

    // Interrupt flag: set two clocks after a B write, held until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_stb_d1 <= 1'b0;
            int_flag <= 1'b0;
        end else begin
            b_stb_d1 <= b_stb;
            if (b_stb_d1) begin
                int_flag <= 1'b1;
            end else if (int_clr) begin
                int_flag <= 1'b0;
            end
        end
    end

    AST_WRITES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_stb, b_stb})) else $error("A and B write together"); // R5
    AST_INT_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flag) |-> $past(b_stb, 2)) else $error("int without B write"); // R7

endmodule

// File: rtl/simsamp_adc_seq.sv
// Top level of the simultaneous-sampling conversion sequencer.
// Joins the start selector, half-period timebase, sample/hold sequencer
// and result delay line.
// The converter model is external: it reads ana_pair and presents
// ana_a/ana_b, which are captured on the hold edge.
module simsamp_adc_seq
    import simsamp_pkg::*;
#(
    parameter int DIV_W  = 4,
    parameter int PAIR_W = 3,
    parameter int ACQ_W  = 4,
    parameter int DW     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [1:0]        trig_sel,
    input  logic              pwm_evt,
    input  logic              sw_start,
    input  logic              ext_soc,
    input  logic [PAIR_W-1:0] pair_sel,
    input  logic [ACQ_W-1:0]  acqps,
    input  logic              cont_en,
    input  logic              int_clr,
    input  logic              ovr_clr,
    input  logic [DW-1:0]     ana_a,
    input  logic [DW-1:0]     ana_b,
    output logic [PAIR_W-1:0] ana_pair,
    output logic              sh_pulse,
    output logic              busy,
    output logic [DW-1:0]     res_a,
    output logic [DW-1:0]     res_b,
    output logic              res_a_stb,
    output logic              res_b_stb,
    output logic              int_flag,
    output logic              overrun
);

    logic trig;
    logic accept;
    logic capture;
    logic half_tick;
    logic pipe_busy;

    adc_trig_select u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (trig_src_e'(trig_sel)),
        .pwm_evt  (pwm_evt),
        .sw_start (sw_start),
        .ext_soc  (ext_soc),
        .trig     (trig)
    );

    adc_timebase #(.DIV_W(DIV_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_div  (half_div),
        .restart   (accept),
        .half_tick (half_tick)
    );

    adc_sh_sequencer #(.PAIR_W(PAIR_W), .ACQ_W(ACQ_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .tick      (half_tick),
        .pipe_busy (pipe_busy),
        .pair_sel  (pair_sel),
        .acqps     (acqps),
        .cont_en   (cont_en),
        .ovr_clr   (ovr_clr),
        .accept    (accept),
        .capture   (capture),
        .sh        (sh_pulse),
        .busy      (busy),
        .overrun   (overrun),
        .pair_q    (ana_pair)
    );

    adc_result_pipe #(.DW(DW)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (half_tick),
        .capture   (capture),
        .samp_a    (ana_a),
        .samp_b    (ana_b),
        .int_clr   (int_clr),
        .res_a     (res_a),
        .res_b     (res_b),
        .a_stb     (res_a_stb),
        .b_stb     (res_b_stb),
        .int_flag  (int_flag),
        .pipe_busy (pipe_busy)
    );

    AST_PAIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ana_pair)) else $error("pair moved"); // R4
    AST_OVR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(busy)) else $error("overrun while idle"); // R8
    AST_IDLE_NO_SH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sh_pulse) else $error("hold pulse while idle"); // R10

endmodule

// File: tb/simsamp_adc_seq_bench.sv
`timescale 1ns/1ps
module simsamp_adc_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  half_div = '0;
    logic [1:0]  trig_sel = '0;
    logic        pwm_evt = 1'b0, sw_start = 1'b0, ext_soc = 1'b0;
    logic [2:0]  pair_sel = '0;
    logic [3:0]  acqps = '0;
    logic        cont_en = 1'b0, int_clr = 1'b0, ovr_clr = 1'b0;
    logic [11:0] ana_a, ana_b;
    logic [2:0]  ana_pair;
    logic        sh_pulse, busy, res_a_stb, res_b_stb, int_flag, overrun;
    logic [11:0] res_a, res_b;

    always #2.5 clk = ~clk;

    // Converter stub: value encodes the pair and a per-sample count.
    logic [7:0] samp_cnt = '0;
    assign ana_a = {ana_pair, 1'b0, samp_cnt};
    assign ana_b = ana_a ^ 12'hFFF;

    simsamp_adc_seq u_simsamp_adc_seq (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .trig_sel(trig_sel),
        .pwm_evt(pwm_evt), .sw_start(sw_start), .ext_soc(ext_soc),
        .pair_sel(pair_sel), .acqps(acqps), .cont_en(cont_en),
        .int_clr(int_clr), .ovr_clr(ovr_clr), .ana_a(ana_a), .ana_b(ana_b),
        .ana_pair(ana_pair), .sh_pulse(sh_pulse), .busy(busy),
        .res_a(res_a), .res_b(res_b), .res_a_stb(res_a_stb),
        .res_b_stb(res_b_stb), .int_flag(int_flag), .overrun(overrun)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Negedge monitor: records edge indices of observed events.
    int n_rise = 0, n_fall = 0, n_a = 0, n_b = 0;
    int t_rise = 0, t_fall = 0, t_a = 0, t_b = 0, t_int = 0, t_bfall = 0;
    int t_a_prev = 0, t_b_prev = 0;
    logic [11:0] a_val = '0, b_val = '0;
    logic sh_q = 0, int_q = 0, busy_q = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sh_pulse && !sh_q) begin n_rise++; t_rise = cyc; end
            if (!sh_pulse && sh_q) begin n_fall++; t_fall = cyc; samp_cnt = samp_cnt + 1; end
            if (res_a_stb) begin n_a++; t_a_prev = t_a; t_a = cyc; a_val = res_a; end
            if (res_b_stb) begin n_b++; t_b_prev = t_b; t_b = cyc; b_val = res_b; end
            if (int_flag && !int_q) t_int = cyc;
            if (!busy && busy_q) t_bfall = cyc;
        end
        sh_q = sh_pulse; int_q = int_flag; busy_q = busy;
    end

    int n_chk = 0, n_bad = 0;
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick_in();
        @(posedge clk); #1;
    endtask

    task automatic fire(input logic [1:0] sel, input logic v);
        case (sel)
            2'd0: pwm_evt = v;
            2'd1: sw_start = v;
            2'd2: ext_soc = v;
            default: pwm_evt = v;
        endcase
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && busy; k++) tick_in();
        repeat (4) tick_in();
    endtask

    // One single conversion with full timing and data checks.
    task automatic run_conv(input logic [1:0] sel, input logic [2:0] pr,
                            input logic [3:0] ac, input logic [3:0] hd, input bit poke);
        int h, t0, nr0, na0, nb0, er, ef;
        logic [11:0] xa;
        h = int'(hd) + 1;
        tick_in();
        trig_sel = sel; pair_sel = pr; acqps = ac; half_div = hd; cont_en = 0;
        tick_in();
        nr0 = n_rise; na0 = n_a; nb0 = n_b;
        xa = {pr, 1'b0, samp_cnt};
        fire(sel, 1'b1);
        tick_in();
        fire(sel, 1'b0);
        t0 = cyc;
        pair_sel = ~pr;
        chk("R4", "locked pair", int'(ana_pair), int'(pr));
        chk("R10", "busy at accept", int'(busy), 1);
        if (poke) begin
            tick_in(); fire(sel, 1'b1); tick_in(); fire(sel, 1'b0);
        end
        wait_idle();
        er = t0 + 5 * h;
        ef = er + 2 * (1 + int'(ac)) * h;
        chk("R2", "rise edge", t_rise, er);
        chk("R2", "rise count", n_rise - nr0, 1);
        chk("R3", "fall edge", t_fall, ef);
        chk("R5", "A write edge", t_a, ef + 8 * h);
        chk("R5", "B write edge", t_b, ef + 10 * h);
        chk("R5", "A/B write counts", (n_a - na0) * 10 + (n_b - nb0), 11);
        chk("R4", "A value", int'(a_val), int'(xa));
        chk("R4", "B value", int'(b_val), int'(xa ^ 12'hFFF));
        chk("R7", "int edge", t_int, ef + 10 * h + 2);
        chk("R10", "busy fall", t_bfall, ef + 10 * h + 1);
        repeat (10) tick_in();
        chk("R7", "int held", int'(int_flag), 1);
        int_clr = 1; tick_in(); int_clr = 0; tick_in();
        chk("R7", "int cleared", int'(int_flag), 0);
    endtask

    // Stimulus vectors: {sel[12:11], pair[10:8], acqps[7:4], half_div[3:0]}
    localparam logic [12:0] VEC [6] = '{
        {2'd0, 3'd0, 4'd0,  4'd0},
        {2'd1, 3'd5, 4'd3,  4'd1},
        {2'd2, 3'd7, 4'd15, 4'd0},
        {2'd0, 3'd2, 4'd7,  4'd3},
        {2'd1, 3'd1, 4'd1,  4'd2},
        {2'd2, 3'd4, 4'd0,  4'd1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int nr0;
        repeat (4) tick_in();
        rst_n = 1;
        tick_in();
        // R9: reset state
        chk("R9", "busy", int'(busy), 0);
        chk("R9", "sh_pulse", int'(sh_pulse), 0);
        chk("R9", "res_a/res_b", int'(res_a) + int'(res_b), 0);
        chk("R9", "strobes", int'(res_a_stb) + int'(res_b_stb), 0);
        chk("R9", "int/overrun", int'(int_flag) + int'(overrun), 0);

        for (int i = 0; i < 6; i++)
            run_conv(VEC[i][12:11], VEC[i][10:8], VEC[i][7:4], VEC[i][3:0], 1'b0);

        // R1: unselected sources and the "none" select do nothing
        nr0 = n_rise;
        trig_sel = 2'd0;
        sw_start = 1; tick_in(); sw_start = 0; ext_soc = 1; tick_in(); ext_soc = 0;
        trig_sel = 2'd3;
        pwm_evt = 1; tick_in(); pwm_evt = 0;
        repeat (100) tick_in();
        chk("R1", "no rise from unselected", n_rise - nr0, 0);
        chk("R1", "busy stays low", int'(busy), 0);

        // R8: second start while busy is ignored and flagged
        chk("R8", "overrun before", int'(overrun), 0);
        run_conv(2'd1, 3'd3, 4'd2, 4'd1, 1'b1);
        chk("R8", "overrun set", int'(overrun), 1);
        ovr_clr = 1; tick_in(); ovr_clr = 0; tick_in();
        chk("R8", "overrun cleared", int'(overrun), 0);

        // R6: continuous mode spacing and stop
        begin
            int na0, nf0, nb0;
            tick_in();
            trig_sel = 2'd0; pair_sel = 3'd6; acqps = 4'd1; half_div = 4'd1; cont_en = 1;
            tick_in();
            na0 = n_a; nb0 = n_b; nf0 = n_fall;
            pwm_evt = 1; tick_in(); pwm_evt = 0;
            for (int k = 0; k < 3000 && (n_b - nb0) < 3; k++) tick_in();
            cont_en = 0;
            chk("R6", "A spacing", t_a - t_a_prev, 2 * (3 + 1) * 2);
            chk("R6", "B spacing", t_b - t_b_prev, 2 * (3 + 1) * 2);
            wait_idle();
            chk("R6", "A writes per fall", n_a - na0, n_fall - nf0);
            chk("R6", "B writes per fall", n_b - nb0, n_fall - nf0);
            chk("R10", "idle after stop", int'(busy), 0);
            int_clr = 1; tick_in(); int_clr = 0;
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule